// File: doc/BRIEF.md
# Width-Converting FIFO with Sub-Word Order Select

This block is a synchronous first-in first-out buffer. Each write stores one full 36-bit word. The read port can hand each stored word back unchanged, or cut it into two 18-bit pieces or four 9-bit pieces and deliver those one per read. It suits a producer that moves wide words and a consumer that takes narrow ones. Both sides share a single clock, and the storage is an internal register array.

Two settings are captured while master reset is held: the width ratio and the sub-word order. In most-significant-first order, the high piece of each stored word is delivered first. In least-significant-first order, the low piece goes first. Both settings stay fixed until the next master reset. A synchronous read select gates the read port. While the select is inactive, the read data register is driven to zero.

Top module: `bmfifo`

## Requirements
- R1: The ratio code on `cfgRatio` is captured during `mrst`. Code 0 gives 1:1 with the whole 36-bit word on `rdData`. Code 1 gives 2:1 with 18-bit pieces on `rdData[17:0]`. Code 2 gives 4:1 with 9-bit pieces on `rdData[8:0]`. Code 3 behaves as 1:1. In every mode, the bits of `rdData` above the piece read as zero.
- R2: With `cfgBigEnd` high during `mrst`, the pieces of each stored word come out most significant first and least significant last.
- R3: With `cfgBigEnd` low during `mrst`, the pieces of each stored word come out least significant first and most significant last.
- R4: `cfgRatio` and `cfgBigEnd` have no effect while `mrst` is low.
- R5: A read is accepted when `rdEn` and `rdCs` are high and `empty` is low. The next piece then appears on `rdData` after the following rising edge. With `rdCs` high and `rdEn` low, `rdData` holds its value.
- R6: With `rdCs` low at a rising edge, `rdData` is zero after that edge.
- R7: A stored word leaves the FIFO only after its last piece has been read. `empty` stays low while any piece of the head word is still unread.
- R8: `full` rises once DEPTH words are stored. A write while `full` is high is discarded.
- R9: A read while `empty` is high changes neither the contents nor `rdData`.
- R10: `mrst` is a synchronous, active-high reset. It leaves `empty` high, `full` low and `rdData` zero, and it discards all stored words, including a word that has been partly read.
- R11: Words come out in write order, including when the storage pointers wrap past the end of the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| mrst | input | 1 | Synchronous master reset, active high; captures the mode inputs |
| cfgRatio | input | 2 | Width ratio code, sampled during reset |
| cfgBigEnd | input | 1 | Sub-word order, sampled during reset: 1 = most significant first |
| wrEn | input | 1 | Write enable |
| wrData | input | 36 | Write word |
| rdEn | input | 1 | Read enable |
| rdCs | input | 1 | Synchronous read select |
| rdData | output | 36 | Read piece, zero-extended; zero while the select is inactive |
| empty | output | 1 | No unread piece is left |
| full | output | 1 | DEPTH words are stored |

## Verification
Every stored word is a pattern whose 9-bit quarters all differ. Any swap, shift or wrong slice therefore produces a mismatch against the queue model. Each ratio is run in both orders. The 4:1 runs separate a full reversal of the quarters from a swap of the halves alone. The 1:1 run with the array filled completely checks the full limit and shows that the rejected write never appears. A long 2:1 stream wraps the pointers several times. A reset in the middle of a word shows that leftover pieces are thrown away.

// File: rtl/bmfifo_pkg.sv
package bmfifo_pkg;

  typedef enum logic [1:0] {
    RATIO_1   = 2'd0,
    RATIO_2   = 2'd1,
    RATIO_4   = 2'd2,
    RATIO_RSV = 2'd3
  } ratio_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       wrStb;
    logic       rdStb;
    logic       idleStb;
    ratio_e     ratio;
    logic [1:0] subPos;
  } strobe_t;

endpackage

// File: rtl/bmfifo_ctrl.sv
module bmfifo_ctrl
  import bmfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic [1:0]    cfgRatio,
  input  logic          cfgBigEnd,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          rdCs,
  output strobe_t       stb,
  output logic [AW-1:0] wrPtr,
  output logic [AW-1:0] rdPtr,
  output logic          empty,
  output logic          full
);

  localparam int CW = $clog2(DEPTH + 1);

  ratio_e        ratioQ;
  logic          bigQ;
  logic [CW-1:0] count;
  logic [1:0]    subIdx;
  logic [1:0]    lastIdx;
  logic          lastSub;
  logic          doWr;
  logic          doRd;

  function automatic logic [AW-1:0] ptrInc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    case (ratioQ)
      RATIO_2: lastIdx = 2'd1;
      RATIO_4: lastIdx = 2'd3;
      default: lastIdx = 2'd0;
    endcase
  end

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign lastSub = (subIdx == lastIdx);
  assign doWr    = wrEn && !full;
  assign doRd    = rdEn && rdCs && !empty;

  always_ff @(posedge clk) begin
    if (mrst) begin
      ratioQ <= ratio_e'(cfgRatio);
      bigQ   <= cfgBigEnd;
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      subIdx <= '0;
    end else begin
      if (doWr) wrPtr <= ptrInc(wrPtr);
      if (doRd) begin
        if (lastSub) begin
          subIdx <= '0;
          rdPtr  <= ptrInc(rdPtr);
        end else begin
          subIdx <= subIdx + 1'b1;
        end
      end
      count <= count + CW'(doWr) - CW'(doRd && lastSub);
    end
  end

  always_comb begin
    stb.wrStb   = doWr;
    stb.rdStb   = doRd;
    stb.idleStb = !rdCs;
    stb.ratio   = ratioQ;
    stb.subPos  = bigQ ? (lastIdx - subIdx) : subIdx;
  end

endmodule

// File: rtl/bmfifo_dpath.sv
module bmfifo_dpath
  import bmfifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              mrst,
  input  strobe_t           stb,
  input  logic [AW-1:0]     wrPtr,
  input  logic [AW-1:0]     rdPtr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int HW = DATA_W / 2;
  localparam int QW = DATA_W / 4;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] headWord;
  logic [DATA_W-1:0] subWord;
  logic [HW-1:0]     half    [2];
  logic [QW-1:0]     quarter [4];

  always_ff @(posedge clk) begin
    if (stb.wrStb) mem[wrPtr] <= wrData;
  end

  assign headWord = mem[rdPtr];

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half[h] = headWord[h*HW +: HW];
  end

  for (genvar q = 0; q < 4; q++) begin : g_quarter
    assign quarter[q] = headWord[q*QW +: QW];
  end

  always_comb begin
    case (stb.ratio)
      RATIO_2: subWord = DATA_W'(half[stb.subPos[0]]);
      RATIO_4: subWord = DATA_W'(quarter[stb.subPos]);
      default: subWord = headWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (mrst || stb.idleStb) rdData <= '0;
    else if (stb.rdStb)      rdData <= subWord;
  end

endmodule

// File: rtl/bmfifo.sv
module bmfifo
  import bmfifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic [1:0]        cfgRatio,
  input  logic              cfgBigEnd,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              rdCs,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              full
);

  localparam int AW = $clog2(DEPTH);

  strobe_t       stb;
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;

  bmfifo_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .mrst(mrst), .cfgRatio(cfgRatio), .cfgBigEnd(cfgBigEnd),
    .wrEn(wrEn), .rdEn(rdEn), .rdCs(rdCs), .stb(stb),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .empty(empty), .full(full)
  );

  bmfifo_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_dpath (
    .clk(clk), .mrst(mrst), .stb(stb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/bmfifo_chk.sv
module bmfifo_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              mrst,
  input logic              wrEn,
  input logic              rdEn,
  input logic              rdCs,
  input logic [DATA_W-1:0] rdData,
  input logic              empty,
  input logic              full
);

  // R10
  reset_state_chk: assert property (@(posedge clk)
    mrst |=> (empty && !full && rdData == '0));

  // R6
  idle_out_chk: assert property (@(posedge clk) disable iff (mrst)
    !rdCs |=> (rdData == '0));

  // R5
  hold_out_chk: assert property (@(posedge clk) disable iff (mrst)
    (rdCs && !rdEn) |=> $stable(rdData));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (mrst)
    (empty && rdCs && !wrEn) |=> (empty && $stable(rdData)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (mrst)
    (full && !(rdEn && rdCs)) |=> full);

endmodule

bind bmfifo bmfifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .mrst(mrst), .wrEn(wrEn), .rdEn(rdEn), .rdCs(rdCs),
  .rdData(rdData), .empty(empty), .full(full)
);

// File: tb/bmfifo_tb.sv
module bmfifo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 36;
  localparam int DEPTH      = 16;

  logic          clk = 1'b0;
  logic          mrst = 1'b1;
  logic [1:0]    cfgRatio = 2'd0;
  logic          cfgBigEnd = 1'b0;
  logic          wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          rdEn = 1'b0;
  logic          rdCs = 1'b1;
  logic [DW-1:0] rdData;
  logic          empty;
  logic          full;

  int            checks = 0;
  int            errors = 0;
  logic [DW-1:0] expQ[$];
  int            mRatio = 0;
  bit            mBig = 1'b0;
  bit            pendCheck = 1'b0;
  string         curTag = "R1";
  logic [DW-1:0] saved;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmfifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .mrst(mrst), .cfgRatio(cfgRatio), .cfgBigEnd(cfgBigEnd),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdCs(rdCs),
    .rdData(rdData), .empty(empty), .full(full)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares each delivered piece against the queue
  always @(negedge clk) begin
    if (pendCheck) begin
      pendCheck = 1'b0;
      if (expQ.size() == 0) check(1'b0, curTag, rdData, '0);
      else begin
        logic [DW-1:0] e;
        e = expQ.pop_front();
        check(rdData === e, curTag, rdData, e);
      end
    end
  end

  task automatic pushPieces(input logic [DW-1:0] w);
    logic [DW-1:0] p[4];
    if (mRatio == 1) begin
      p[0] = {18'b0, w[17:0]};  p[1] = {18'b0, w[35:18]};
      if (mBig) begin expQ.push_back(p[1]); expQ.push_back(p[0]); end
      else      begin expQ.push_back(p[0]); expQ.push_back(p[1]); end
    end else if (mRatio == 2) begin
      for (int i = 0; i < 4; i++) p[i] = {27'b0, w[i*9 +: 9]};
      for (int i = 0; i < 4; i++) expQ.push_back(mBig ? p[3-i] : p[i]);
    end else begin
      expQ.push_back(w);
    end
  endtask

  task automatic doReset(input int ratio, input bit big);
    @(negedge clk);
    mrst = 1'b1; cfgRatio = 2'(ratio); cfgBigEnd = big;
    wrEn = 1'b0; rdEn = 1'b0; rdCs = 1'b1;
    @(negedge clk);
    mrst = 1'b0;
    expQ.delete();
    mRatio = (ratio == 3) ? 0 : ratio;
    mBig = big;
    check(empty === 1'b1 && full === 1'b0 && rdData === '0, "R10", rdData, '0);
  endtask

  task automatic writeWord(input logic [DW-1:0] w, input bit accept);
    @(negedge clk);
    wrEn = 1'b1; wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
    if (accept) pushPieces(w);
  endtask

  task automatic readPiece();
    bit have;
    @(negedge clk);
    rdEn = 1'b1; rdCs = 1'b1;
    have = (expQ.size() != 0);
    @(posedge clk);
    if (have) pendCheck = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int n);
    logic [DW-1:0] w;
    for (int q = 0; q < 4; q++) w[q*9 +: 9] = 9'((n * 37 + q * 101 + 5) & 9'h1ff);
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // 1:1 mode
    doReset(0, 1'b0);
    curTag = "R1";
    for (int i = 0; i < 3; i++) writeWord(pat(i), 1'b1);
    for (int i = 0; i < 3; i++) readPiece();
    // reserved code acts as 1:1
    doReset(3, 1'b1);
    curTag = "R1";
    writeWord(pat(9), 1'b1);
    readPiece();

    // 4:1 most significant first; mode inputs changed after reset (R4)
    doReset(2, 1'b1);
    cfgRatio = 2'd0; cfgBigEnd = 1'b0;
    curTag = "R2";
    for (int i = 0; i < 3; i++) writeWord(pat(10 + i), 1'b1);
    for (int i = 0; i < 12; i++) readPiece();
    curTag = "R4";
    writeWord(pat(20), 1'b1);
    for (int i = 0; i < 4; i++) readPiece();

    // 2:1 least significant first
    doReset(1, 1'b0);
    curTag = "R3";
    for (int i = 0; i < 3; i++) writeWord(pat(30 + i), 1'b1);
    for (int i = 0; i < 6; i++) readPiece();

    // 4:1 least significant first: hold, idle, retire, underflow
    doReset(2, 1'b0);
    curTag = "R3";
    writeWord(pat(40), 1'b1);
    for (int i = 0; i < 3; i++) readPiece();
    check(empty === 1'b0, "R7", {35'b0, empty}, 36'd0);
    saved = rdData;
    @(negedge clk); @(negedge clk);
    check(rdData === saved, "R5", rdData, saved);
    rdCs = 1'b0;
    @(negedge clk);
    check(rdData === '0, "R6", rdData, '0);
    rdCs = 1'b1;
    readPiece();
    check(empty === 1'b1, "R7", {35'b0, empty}, 36'd1);
    saved = rdData;
    readPiece();
    check(rdData === saved && empty === 1'b1, "R9", rdData, saved);

    // full limit in 1:1
    doReset(0, 1'b0);
    curTag = "R8";
    for (int i = 0; i < DEPTH; i++) writeWord(pat(50 + i), 1'b1);
    check(full === 1'b1, "R8", {35'b0, full}, 36'd1);
    writeWord(36'hfff_fff_fff, 1'b0);
    check(full === 1'b1, "R8", {35'b0, full}, 36'd1);
    for (int i = 0; i < DEPTH; i++) readPiece();
    check(empty === 1'b1 && full === 1'b0, "R8", {34'b0, full, empty}, 36'd1);

    // wrap in 2:1 most significant first
    doReset(1, 1'b1);
    curTag = "R11";
    for (int i = 0; i < 3; i++) writeWord(pat(80 + i), 1'b1);
    for (int i = 0; i < 2 * DEPTH + 3; i++) begin
      writeWord(pat(90 + i), 1'b1);
      readPiece(); readPiece();
    end
    for (int i = 0; i < 6; i++) readPiece();
    check(empty === 1'b1, "R11", {35'b0, empty}, 36'd1);

    // reset in the middle of a word
    doReset(2, 1'b1);
    curTag = "R10";
    writeWord(pat(200), 1'b1);
    readPiece();
    doReset(2, 1'b1);
    curTag = "R10";
    writeWord(pat(201), 1'b1);
    readPiece();
    check(empty === 1'b0, "R10", {35'b0, empty}, 36'd0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule